// File: doc/BRIEF.md
# Instruction Fault-Injection Mutator

This block sits on a 32-bit, MIPS-style instruction fetch path and corrupts one instruction word on request, for fault-injection experiments. Each valid-qualified beat carries an instruction, a 32-bit control word taken from an outside random source, and a request flag. When a mutation is requested, the block decodes the instruction's class to find a field worth corrupting. It then deletes the instruction, swaps one register number, or turns a branch condition into its inverted or off-by-one partner. It does not flip arbitrary bits.

The result leaves one clock later with a status. The status is done (a mutated word was produced), retry (this instruction cannot be mutated and the caller should pick another), or illegal (the function or condition code is not a known one). Words that are not mutated, retried or illegal leave unchanged, so the block can stay in the fetch path at all times.

Top module: `insn_mutator`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly one clock. After a synchronous active-low reset, `out_valid` and all three status outputs are 0.
- R2: A beat with `in_req` = 0 leaves with its instruction unchanged and with done, retry and illegal all 0.
- R3: A requested beat whose instruction is 32'h0 yields retry and the word 32'h0, whatever the control word holds.
- R4: Control bits [29:28] = 0 select delete. Any non-zero instruction then yields 32'h0 with done, even one whose class would otherwise retry. The values 1, 2 and 3 select modify. Bits [22:0] have no effect.
- R5: A register substitution writes control bits [27:23] into the chosen 5-bit field (rs at [25:21], rt at [20:16], rd at [15:11]). When that number equals the field's present value, (value+1) mod 32 is written instead. All other bits are kept.
- R6: Primary opcode 0 with an ALU or shift function (add, addu, sub, subu, and, or, xor, nor, slt, sltu, sll, srl, sra, sllv, srlv, srav) alters rd when bit 30 = 0. When bit 30 = 1 it alters rs if bit 31 = 1 and rt if bit 31 = 0.
- R7: Multiply and divide functions alter rs if bit 31 = 1, else rt. mfhi and mflo alter rd. mthi and mtlo alter rs. jr, jalr, syscall, break and sync give retry.
- R8: addi, addiu, andi, slti, sltiu and xori alter rt when bit 30 = 0 and rs when bit 30 = 1. lui and ori give retry.
- R9: For beq (4), bne (5), beql (20) and bnel (21), bit 30 = 0 swaps the opcode 4↔5 and 20↔21 and keeps bits [25:0]. Bit 30 = 1 alters rs or rt per bit 31. beq with rs = rt = 0 gives retry in every modify mode.
- R10: For blez (6), bgtz (7), blezl (22) and bgtzl (23), bit 30 = 0 re-encodes the instruction as opcode 1 with rt = 0 (bltz), 1 (bgez), 2 (bltzl) and 3 (bgezl) respectively, keeping rs and the immediate. Bit 30 = 1 alters rs.
- R11: For opcode 1, bit 30 = 0 maps rt condition 1→opcode 7, 3→23, 0→6 and 2→22, with rt cleared and rs and the immediate kept. It toggles rt 16↔17 and 18↔19 in place. Bit 30 = 1 alters rs.
- R12: All other primary opcodes (jumps, cache, prefetch, loads, stores, coprocessor and unassigned codes) give retry in modify mode.
- R13: An unknown function code under opcode 0, or an unknown rt condition under opcode 1, gives illegal in modify mode. Retry and illegal beats leave the instruction unchanged.
- R14: Every requested beat leaves with exactly one of done, retry and illegal set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat is valid |
| in_req | input | 1 | Mutation requested for this beat |
| in_insn | input | 32 | Instruction word |
| in_ctrl | input | 32 | Random control word (bit 31 rs/rt, bit 30 source/destination, bits 29:28 delete/modify, bits 27:23 register) |
| out_valid | output | 1 | Output beat is valid |
| out_insn | output | 32 | Resulting instruction word |
| out_done | output | 1 | A mutated word was produced |
| out_retry | output | 1 | The instruction cannot be mutated |
| out_illegal | output | 1 | Unknown function or condition code |

## Verification
Every result depends on a single input beat and is due on the clock edge right after that beat is presented. The bench's driver sets a beat up on a falling edge and pushes its expected word and status into a queue. The monitor compares on the next falling edge, half a period after the result registers load. A valid output with nothing queued, or an idle cycle that still shows `out_valid`, counts as a latency failure. The queue must be empty at the end.

// File: rtl/insn_mutator_pkg.sv
// Package: shared encodings for the instruction mutator.
// Assumes a 32-bit MIPS-style word: 6-bit opcode, three 5-bit register fields.
package insn_mutator_pkg;

    localparam int INSN_W = 32;
    localparam int REG_W  = 5;
    localparam int OP_W   = 6;
    localparam int FN_W   = 6;
    localparam int NUM_FIELDS = 3;

    // primary opcodes
    localparam logic [OP_W-1:0] OP_SPECIAL = 6'd0;
    localparam logic [OP_W-1:0] OP_REGIMM  = 6'd1;
    localparam logic [OP_W-1:0] OP_BEQ     = 6'd4;
    localparam logic [OP_W-1:0] OP_BNE     = 6'd5;
    localparam logic [OP_W-1:0] OP_BLEZ    = 6'd6;
    localparam logic [OP_W-1:0] OP_BGTZ    = 6'd7;
    localparam logic [OP_W-1:0] OP_ADDI    = 6'd8;
    localparam logic [OP_W-1:0] OP_ADDIU   = 6'd9;
    localparam logic [OP_W-1:0] OP_SLTI    = 6'd10;
    localparam logic [OP_W-1:0] OP_SLTIU   = 6'd11;
    localparam logic [OP_W-1:0] OP_ANDI    = 6'd12;
    localparam logic [OP_W-1:0] OP_XORI    = 6'd14;
    localparam logic [OP_W-1:0] OP_BEQL    = 6'd20;
    localparam logic [OP_W-1:0] OP_BNEL    = 6'd21;
    localparam logic [OP_W-1:0] OP_BLEZL   = 6'd22;
    localparam logic [OP_W-1:0] OP_BGTZL   = 6'd23;

    // register-branch conditions carried in rt under OP_REGIMM
    localparam logic [REG_W-1:0] RC_LTZ     = 5'd0;
    localparam logic [REG_W-1:0] RC_GEZ     = 5'd1;
    localparam logic [REG_W-1:0] RC_LTZL    = 5'd2;
    localparam logic [REG_W-1:0] RC_GEZL    = 5'd3;
    localparam logic [REG_W-1:0] RC_LTZAL   = 5'd16;
    localparam logic [REG_W-1:0] RC_GEZAL   = 5'd17;
    localparam logic [REG_W-1:0] RC_LTZALL  = 5'd18;
    localparam logic [REG_W-1:0] RC_GEZALL  = 5'd19;

    // what the decoder wants done with a word
    typedef enum logic [1:0] {
        ACT_RETRY   = 2'd0,
        ACT_ILLEGAL = 2'd1,
        ACT_FIELD   = 2'd2,
        ACT_REWRITE = 2'd3
    } act_e;

    // register field to substitute; value is the field index
    typedef enum logic [1:0] {
        FLD_RS = 2'd0,
        FLD_RT = 2'd1,
        FLD_RD = 2'd2
    } fld_e;

    typedef struct packed {
        act_e              act;
        fld_e              fld;
        logic [INSN_W-1:0] word;   // rewritten word for ACT_REWRITE
    } plan_t;

    // bit position of register field i (rs, rt, rd)
    function automatic int field_lsb(input int idx);
        return 21 - REG_W * idx;
    endfunction

endpackage

// File: rtl/mut_decode.sv
// Module: mut_decode
// Classifies an instruction and picks a mutation: a register field to
// substitute, a rewritten branch word, retry or illegal. Purely combinational.
// Assumes the caller has already handled zero words and delete mode.
module mut_decode
    import insn_mutator_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    input  logic              pick_src,   // 1: alter a source, 0: a destination
    input  logic              pick_rs,    // 1: rs, 0: rt when a source is altered
    output plan_t             plan
);

    logic [OP_W-1:0]  opc;
    logic [FN_W-1:0]  fn;
    logic [REG_W-1:0] rs_f;
    logic [REG_W-1:0] rt_f;
    fld_e             src_fld;

    assign opc     = insn[31:26];
    assign fn      = insn[5:0];
    assign rs_f    = insn[25:21];
    assign rt_f    = insn[20:16];
    assign src_fld = pick_rs ? FLD_RS : FLD_RT;

    // decode class and choose the action
    always_comb begin
        plan.act  = ACT_RETRY;
        plan.fld  = FLD_RS;
        plan.word = insn;
        case (opc)
            OP_SPECIAL: begin
                case (fn)
                    6'd0, 6'd2, 6'd3, 6'd4, 6'd6, 6'd7,
                    6'd32, 6'd33, 6'd34, 6'd35, 6'd36, 6'd37,
                    6'd38, 6'd39, 6'd42, 6'd43: begin
                        plan.act = ACT_FIELD;
                        plan.fld = pick_src ? src_fld : FLD_RD;
                    end
                    6'd24, 6'd25, 6'd26, 6'd27: begin
                        plan.act = ACT_FIELD;
                        plan.fld = src_fld;
                    end
                    6'd16, 6'd18: begin
                        plan.act = ACT_FIELD;
                        plan.fld = FLD_RD;
                    end
                    6'd17, 6'd19: begin
                        plan.act = ACT_FIELD;
                        plan.fld = FLD_RS;
                    end
                    6'd8, 6'd9, 6'd12, 6'd13, 6'd15: plan.act = ACT_RETRY;
                    default: plan.act = ACT_ILLEGAL;
                endcase
            end
            OP_REGIMM: begin
                plan.act = pick_src ? ACT_FIELD : ACT_REWRITE;
                plan.fld = FLD_RS;
                case (rt_f)
                    RC_GEZ:    plan.word = {OP_BGTZ,  rs_f, 5'd0, insn[15:0]};
                    RC_GEZL:   plan.word = {OP_BGTZL, rs_f, 5'd0, insn[15:0]};
                    RC_LTZ:    plan.word = {OP_BLEZ,  rs_f, 5'd0, insn[15:0]};
                    RC_LTZL:   plan.word = {OP_BLEZL, rs_f, 5'd0, insn[15:0]};
                    RC_GEZAL:  plan.word = {OP_REGIMM, rs_f, RC_LTZAL,  insn[15:0]};
                    RC_LTZAL:  plan.word = {OP_REGIMM, rs_f, RC_GEZAL,  insn[15:0]};
                    RC_GEZALL: plan.word = {OP_REGIMM, rs_f, RC_LTZALL, insn[15:0]};
                    RC_LTZALL: plan.word = {OP_REGIMM, rs_f, RC_GEZALL, insn[15:0]};
                    default:   plan.act  = ACT_ILLEGAL;
                endcase
            end
            OP_BEQ, OP_BNE, OP_BEQL, OP_BNEL: begin
                plan.act  = pick_src ? ACT_FIELD : ACT_REWRITE;
                plan.fld  = src_fld;
                // opcode bit 0 separates equal from not-equal in both pairs
                plan.word = {opc[5:1], ~opc[0], insn[25:0]};
                if (opc == OP_BEQ && rs_f == '0 && rt_f == '0)
                    plan.act = ACT_RETRY;
            end
            OP_BLEZ, OP_BGTZ, OP_BLEZL, OP_BGTZL: begin
                plan.act = pick_src ? ACT_FIELD : ACT_REWRITE;
                plan.fld = FLD_RS;
                case (opc)
                    OP_BGTZ:  plan.word = {OP_REGIMM, rs_f, RC_GEZ,  insn[15:0]};
                    OP_BGTZL: plan.word = {OP_REGIMM, rs_f, RC_GEZL, insn[15:0]};
                    OP_BLEZ:  plan.word = {OP_REGIMM, rs_f, RC_LTZ,  insn[15:0]};
                    default:  plan.word = {OP_REGIMM, rs_f, RC_LTZL, insn[15:0]};
                endcase
            end
            OP_ADDI, OP_ADDIU, OP_SLTI, OP_SLTIU, OP_ANDI, OP_XORI: begin
                plan.act = ACT_FIELD;
                plan.fld = pick_src ? FLD_RS : FLD_RT;
            end
            default: plan.act = ACT_RETRY;
        endcase
    end

endmodule

// File: rtl/mut_field_sub.sv
// Module: mut_field_sub
// Replaces one 5-bit register field with a new number, stepping to the next
// number (mod 32) when the new one equals the present value. Combinational.
// Assumes fld is one of rs, rt, rd.
module mut_field_sub
    import insn_mutator_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    input  fld_e              fld,
    input  logic [REG_W-1:0]  new_reg,
    output logic [INSN_W-1:0] word
);

    logic [INSN_W-1:0] cand [NUM_FIELDS];

    // one candidate word per register field
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        localparam int LSB = field_lsb(f);
        logic [REG_W-1:0] cur;
        logic [REG_W-1:0] nr;
        assign cur     = insn[LSB +: REG_W];
        assign nr      = (new_reg == cur) ? REG_W'(new_reg + 1'b1) : new_reg;
        assign cand[f] = (insn & ~(INSN_W'({REG_W{1'b1}}) << LSB))
                       | (INSN_W'(nr) << LSB);
    end

    // select the candidate for the requested field
    always_comb begin
        case (fld)
            FLD_RS:  word = cand[0];
            FLD_RT:  word = cand[1];
            default: word = cand[2];
        endcase
    end

endmodule

// File: rtl/insn_mutator.sv
// Module: insn_mutator (top)
// Mutates one requested instruction per beat and registers the word and a
// status with one cycle of latency. Assumes in_ctrl is freshly random per
// request; in_ctrl[22:0] is not used.
module insn_mutator
    import insn_mutator_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_req,
    input  logic [INSN_W-1:0] in_insn,
    input  logic [INSN_W-1:0] in_ctrl,
    output logic              out_valid,
    output logic [INSN_W-1:0] out_insn,
    output logic              out_done,
    output logic              out_retry,
    output logic              out_illegal
);

    logic              ctl_rs;
    logic              ctl_src;
    logic [1:0]        ctl_mode;
    logic [REG_W-1:0]  ctl_reg;
    logic              unused_ctrl;
    plan_t             plan;
    logic [INSN_W-1:0] sub_word;
    logic [INSN_W-1:0] nxt_insn;
    logic              nxt_done;
    logic              nxt_retry;
    logic              nxt_illegal;

    assign ctl_rs      = in_ctrl[31];
    assign ctl_src     = in_ctrl[30];
    assign ctl_mode    = in_ctrl[29:28];
    assign ctl_reg     = in_ctrl[27:23];
    assign unused_ctrl = ^in_ctrl[22:0];

    mut_decode u_decode (
        .insn     (in_insn),
        .pick_src (ctl_src),
        .pick_rs  (ctl_rs),
        .plan     (plan)
    );

    mut_field_sub u_sub (
        .insn    (in_insn),
        .fld     (plan.fld),
        .new_reg (ctl_reg),
        .word    (sub_word)
    );

    // apply request, zero-word and delete precedence over the decoded plan
    always_comb begin
        nxt_insn    = in_insn;
        nxt_done    = 1'b0;
        nxt_retry   = 1'b0;
        nxt_illegal = 1'b0;
        if (in_req) begin
            if (in_insn == '0) begin
                nxt_retry = 1'b1;
            end else if (ctl_mode == 2'd0) begin
                nxt_insn = '0;
                nxt_done = 1'b1;
            end else begin
                case (plan.act)
                    ACT_FIELD: begin
                        nxt_insn = sub_word;
                        nxt_done = 1'b1;
                    end
                    ACT_REWRITE: begin
                        nxt_insn = plan.word;
                        nxt_done = 1'b1;
                    end
                    ACT_ILLEGAL: nxt_illegal = 1'b1;
                    default:     nxt_retry   = 1'b1;
                endcase
            end
        end
    end

    // output register stage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_insn    <= '0;
            out_done    <= 1'b0;
            out_retry   <= 1'b0;
            out_illegal <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_insn    <= nxt_insn;
            out_done    <= in_valid & nxt_done;
            out_retry   <= in_valid & nxt_retry;
            out_illegal <= in_valid & nxt_illegal;
        end
    end

    // R1: output valid tracks input valid one cycle later
    p_valid_lag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_lag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !out_done && !out_retry && !out_illegal);

    // R2: no request means untouched word and no status
    p_no_req_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_req |=> !out_done && !out_retry && !out_illegal
                                && out_insn == $past(in_insn));

    // R3: zero instruction is retried unchanged
    p_zero_retry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_req && in_insn == '0 |=> out_retry && out_insn == '0);

    // R4: delete mode yields a zero word with done
    p_delete_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_req && in_insn != '0 && in_ctrl[29:28] == 2'd0
        |=> out_done && out_insn == '0);

    // R13: retry and illegal beats leave the word unchanged
    p_keep_word_r13: assert property (@(posedge clk) disable iff (!rst_n)
        out_retry || out_illegal |-> out_insn == $past(in_insn));

    // R14: exactly one status on every requested beat
    p_one_status_r14: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_req |=> $countones({out_done, out_retry, out_illegal}) == 1);

endmodule

// File: tb/insn_mutator_bench.sv
// Scoreboard bench: driver pushes expected results, monitor pops and compares.
module insn_mutator_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_req = 1'b0;
    logic [31:0] in_insn = '0;
    logic [31:0] in_ctrl = '0;
    logic        out_valid;
    logic [31:0] out_insn;
    logic        out_done;
    logic        out_retry;
    logic        out_illegal;

    int checks = 0;
    int errors = 0;

    // status encoding {illegal, retry, done}
    localparam logic [2:0] S_NONE = 3'b000;
    localparam logic [2:0] S_DONE = 3'b001;
    localparam logic [2:0] S_RETRY = 3'b010;
    localparam logic [2:0] S_ILL = 3'b100;

    typedef struct {
        logic [31:0] insn;
        logic [2:0]  st;
        string       tag;
    } exp_t;

    exp_t sb [$];

    always #2 clk = ~clk;   // 250 MHz

    insn_mutator u_insn_mutator (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_req (in_req),
        .in_insn (in_insn), .in_ctrl (in_ctrl), .out_valid (out_valid),
        .out_insn (out_insn), .out_done (out_done), .out_retry (out_retry),
        .out_illegal (out_illegal)
    );

    function automatic logic [31:0] rw(input int rs, input int rt, input int rd,
                                       input int sh, input int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
    endfunction

    function automatic logic [31:0] iw(input int op, input int rs, input int rt,
                                       input logic [15:0] imm);
        return {6'(op), 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] ctl(input bit rs, input bit src,
                                        input int md, input int r);
        return {rs, src, 2'(md), 5'(r), 23'h2B3C5D};
    endfunction

    // drive one beat and queue its expected result
    task automatic send(input logic [31:0] insn, input logic [31:0] ctrl,
                        input logic req, input logic [31:0] ei,
                        input logic [2:0] es, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_req   = req;
        in_insn  = insn;
        in_ctrl  = ctrl;
        e.insn = ei; e.st = es; e.tag = tag;
        sb.push_back(e);
    endtask

    // idle cycle; one cycle later out_valid must be low (R1)
    task automatic bubble();
        @(negedge clk);
        in_valid = 1'b0;
        in_req   = 1'b1;
        in_insn  = 32'hDEAD_BEEF;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 idle out_valid=%b exp 0", out_valid);
        end
    endtask

    // monitor: pop and compare every valid output
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R1 unexpected out_valid=1 exp 0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (out_insn !== e.insn ||
                    {out_illegal, out_retry, out_done} !== e.st) begin
                    errors++;
                    $display("FAIL %s insn=%h exp %h status=%b exp %b", e.tag,
                             out_insn, e.insn,
                             {out_illegal, out_retry, out_done}, e.st);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;   // R1 reset state
        if ({out_valid, out_done, out_retry, out_illegal} !== 4'b0) begin
            errors++;
            $display("FAIL R1 reset outputs=%b exp 0000",
                     {out_valid, out_done, out_retry, out_illegal});
        end
        rst_n = 1'b1;

        send(rw(1,2,3,0,32), ctl(0,0,1,9), 1'b0, rw(1,2,3,0,32), S_NONE, "R2 no request");
        send(32'h0, ctl(1,1,2,4), 1'b1, 32'h0, S_RETRY, "R3 zero word");
        send(iw(2,3,4,16'h1234), ctl(0,0,0,4), 1'b1, 32'h0, S_DONE, "R4 delete jump");
        send(rw(1,2,3,0,32), ctl(0,0,1,9), 1'b1, rw(1,2,9,0,32), S_DONE, "R6 add rd");
        send(rw(1,2,3,0,32), ctl(0,0,3,3), 1'b1, rw(1,2,4,0,32), S_DONE, "R5 collision");
        send(rw(1,2,31,0,36), ctl(0,0,2,31), 1'b1, rw(1,2,0,0,36), S_DONE, "R5 wrap");
        send(rw(4,5,6,0,34), ctl(1,1,3,7), 1'b1, rw(7,5,6,0,34), S_DONE, "R6 sub rs");
        send(rw(0,5,6,3,0), ctl(0,1,1,10), 1'b1, rw(0,10,6,3,0), S_DONE, "R6 sll rt");
        bubble();
        send(rw(8,9,0,0,24), ctl(1,0,1,12), 1'b1, rw(12,9,0,0,24), S_DONE, "R7 mult rs");
        send(rw(0,0,5,0,18), ctl(1,1,1,20), 1'b1, rw(0,0,20,0,18), S_DONE, "R7 mflo rd");
        send(rw(6,0,0,0,19), ctl(0,0,1,2), 1'b1, rw(2,0,0,0,19), S_DONE, "R7 mtlo rs");
        send(rw(31,0,0,0,8), ctl(0,0,1,2), 1'b1, rw(31,0,0,0,8), S_RETRY, "R7 jr retry");
        send(rw(1,2,3,0,1), ctl(0,0,1,2), 1'b1, rw(1,2,3,0,1), S_ILL, "R13 bad funct");
        send(iw(8,3,4,16'h1234), ctl(1,0,1,17), 1'b1, iw(8,3,17,16'h1234), S_DONE, "R8 addi rt");
        send(iw(14,3,4,16'h00FF), ctl(0,1,1,3), 1'b1, iw(14,4,4,16'h00FF), S_DONE, "R8 xori rs");
        send(iw(15,0,4,16'h0001), ctl(0,0,1,3), 1'b1, iw(15,0,4,16'h0001), S_RETRY, "R8 lui retry");
        send(iw(4,1,2,16'h0010), ctl(0,0,1,0), 1'b1, iw(5,1,2,16'h0010), S_DONE, "R9 beq to bne");
        send(iw(21,1,2,16'h0010), ctl(1,0,2,0), 1'b1, iw(20,1,2,16'h0010), S_DONE, "R9 bnel to beql");
        send(iw(5,1,2,16'h0008), ctl(0,1,1,9), 1'b1, iw(5,1,9,16'h0008), S_DONE, "R9 bne rt");
        send(iw(4,0,0,16'h0010), ctl(0,1,1,5), 1'b1, iw(4,0,0,16'h0010), S_RETRY, "R9 b retry");
        send(iw(23,7,0,16'hFFF0), ctl(0,0,1,0), 1'b1, iw(1,7,3,16'hFFF0), S_DONE, "R10 bgtzl");
        send(iw(6,7,0,16'h0004), ctl(0,1,1,7), 1'b1, iw(6,8,0,16'h0004), S_DONE, "R10 blez rs");
        send(iw(1,9,0,16'h0020), ctl(0,0,1,0), 1'b1, iw(6,9,0,16'h0020), S_DONE, "R11 bltz");
        send(iw(1,9,3,16'h0020), ctl(0,0,1,0), 1'b1, iw(23,9,0,16'h0020), S_DONE, "R11 bgezl");
        send(iw(1,9,17,16'h0020), ctl(0,0,1,0), 1'b1, iw(1,9,16,16'h0020), S_DONE, "R11 bgezal");
        send(iw(1,9,18,16'h0020), ctl(0,0,1,0), 1'b1, iw(1,9,19,16'h0020), S_DONE, "R11 bltzall");
        send(iw(1,9,1,16'h0020), ctl(0,1,1,4), 1'b1, iw(1,4,1,16'h0020), S_DONE, "R11 rs");
        send(iw(1,9,5,16'h0020), ctl(0,0,1,0), 1'b1, iw(1,9,5,16'h0020), S_ILL, "R13 bad cond");
        send(iw(35,2,3,16'h0004), ctl(1,1,1,6), 1'b1, iw(35,2,3,16'h0004), S_RETRY, "R12 lw");
        send(iw(43,2,3,16'h0004), ctl(0,0,2,6), 1'b1, iw(43,2,3,16'h0004), S_RETRY, "R12 sw");
        send(iw(17,2,3,16'h0004), ctl(0,1,3,6), 1'b1, iw(17,2,3,16'h0004), S_RETRY, "R12 cop1");
        bubble();
        bubble();

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R14 pending results=%0d exp 0", sb.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule